// File: doc/BRIEF.md
# SPI Interrupt Request Controller

This block turns the status of a serial peripheral port into interrupt requests for the processor. The port runs in one of two modes. In processor-driven mode, software moves each word, and the block asks for service whenever the receive buffer holds data or the transmit buffer has room. In DMA-driven mode, a DMA engine moves the data. The block then interrupts either on transfer progress (a single block finishing or a whole chain finishing) or on error status (multimaster conflict, transmit underflow, receive overflow). The direction of operation decides which of the last two errors counts.

Every qualifying cause sets two request latches together, one for a high-priority line and one for a low-priority line. Software picks the priority it wants by unmasking only one of the two lines. Each output is its latch gated by its own mask and by a global interrupt enable. The interrupt handler pulses a clear input to drop both latches once the cause has been serviced.

Top module: `spi_irq_ctrl`

## Requirements
- R1: In DMA mode (`cfg_dma_en`=1) with `cfg_xfer_ie`=1, a `dma_done` pulse sets the request latches on the next clock edge. With `cfg_xfer_ie`=0 the pulse has no effect.
- R2: In DMA mode with `cfg_xfer_ie`=1, a `chain_done` pulse sets the request latches on the next clock edge.
- R3: Any cause sets the high-priority and the low-priority latches in the same cycle, so with both masks and the global enable at 1, `irq_hi` and `irq_lo` are always equal.
- R4: In DMA mode, completion pulses are taken only when `cfg_xfer_ie`=1, and error flags are taken only when `cfg_err_ie`=1.
- R5: In DMA mode with `cfg_err_ie`=1, `mm_err` sets the latches whatever the direction.
- R6: In DMA mode with `cfg_err_ie`=1, `tx_underflow` sets the latches only when `cfg_tx_init`=1, and `rx_overflow` sets them only when `cfg_tx_init`=0.
- R7: With `cfg_dma_en`=0, `rx_not_empty`=1 or `tx_not_full`=1 sets the latches regardless of the enable bits. In DMA mode these two status inputs have no effect.
- R8: With `cfg_dma_en`=0, the error inputs (`mm_err`, `tx_underflow`, `rx_overflow`) and the completion pulses never set the latches.
- R9: `irq_hi` = latch & `mask_hi` & `glb_en`, and `irq_lo` = latch & `mask_lo` & `glb_en`. Masking does not clear a latch, so a later unmask exposes the pending request.
- R10: The latches hold until `irq_clr` is high at a clock edge with no cause present. If a cause is present in the same cycle as the clear, the latches stay set. Synchronous reset `rst` clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dma_en | input | 1 | 1 = DMA-driven mode, 0 = processor-driven mode |
| cfg_xfer_ie | input | 1 | DMA mode: interrupt on transfer completion |
| cfg_err_ie | input | 1 | DMA mode: interrupt on error status |
| cfg_tx_init | input | 1 | 1 = transmit-initiated, 0 = receive-initiated |
| dma_done | input | 1 | Pulse: single DMA transfer finished |
| chain_done | input | 1 | Pulse: DMA chain finished |
| mm_err | input | 1 | Multimaster error flag |
| tx_underflow | input | 1 | Transmit underflow flag |
| rx_overflow | input | 1 | Receive overflow flag |
| rx_not_empty | input | 1 | Receive buffer holds data |
| tx_not_full | input | 1 | Transmit buffer has room |
| mask_hi | input | 1 | High-priority line enable (1 = unmasked) |
| mask_lo | input | 1 | Low-priority line enable (1 = unmasked) |
| glb_en | input | 1 | Global interrupt enable |
| irq_clr | input | 1 | Handler clear of both latches |
| irq_hi | output | 1 | High-priority interrupt request |
| irq_lo | output | 1 | Low-priority interrupt request |

## Verification
The cause decode is tried with one source active at a time across the combinations of mode, enable selection and direction. Each underflow and overflow case is run in both directions, and each completion pulse is run with its enable both on and off. This separates a decode that ignores the direction or the enable selection from a correct one. Buffer status is applied in both modes, and error flags are applied in processor-driven mode, which shows that each source is confined to its own mode. Directed cases then set a cause in the same cycle as a clear, set only one mask, and drop the global enable. These tell apart a clear that wins over a cause, and a mask that discards the pending state, from the intended behaviour.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int NUM_LINES = 2;
    localparam int LINE_HI   = 0;
    localparam int LINE_LO   = 1;

    typedef struct packed {
        logic dma_en;
        logic xfer_ie;
        logic err_ie;
        logic tx_init;
    } irq_cfg_t;

    typedef struct packed {
        logic dma_done;
        logic chain_done;
        logic mm_err;
        logic tx_underflow;
        logic rx_overflow;
        logic rx_not_empty;
        logic tx_not_full;
    } irq_src_t;

    function automatic logic dma_err_hit(irq_cfg_t c, irq_src_t s);
        return s.mm_err
            | (s.tx_underflow &  c.tx_init)
            | (s.rx_overflow  & ~c.tx_init);
    endfunction

endpackage

// File: rtl/spi_irq_cause.sv
module spi_irq_cause
    import spi_irq_pkg::*;
(
    input  irq_cfg_t cfg,
    input  irq_src_t src,
    output logic     cause
);
    logic xfer_hit;
    logic err_hit;
    logic core_hit;

    always_comb begin
        xfer_hit = cfg.dma_en & cfg.xfer_ie & (src.dma_done | src.chain_done);
        err_hit  = cfg.dma_en & cfg.err_ie  & dma_err_hit(cfg, src);
        core_hit = ~cfg.dma_en & (src.rx_not_empty | src.tx_not_full);
        cause    = xfer_hit | err_hit | core_hit;
    end
endmodule

// File: rtl/spi_irq_latch.sv
module spi_irq_latch #(
    parameter int LINES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cause,
    input  logic             clr,
    output logic [LINES-1:0] pend
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                pend[i] <= 1'b0;
            else if (cause)
                pend[i] <= 1'b1;
            else if (clr)
                pend[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_irq_gate.sv
module spi_irq_gate #(
    parameter int LINES = 2
) (
    input  logic [LINES-1:0] pend,
    input  logic [LINES-1:0] mask,
    input  logic             glb_en,
    output logic [LINES-1:0] req
);
    always_comb req = pend & mask & {LINES{glb_en}};
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
    import spi_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_dma_en,
    input  logic cfg_xfer_ie,
    input  logic cfg_err_ie,
    input  logic cfg_tx_init,
    input  logic dma_done,
    input  logic chain_done,
    input  logic mm_err,
    input  logic tx_underflow,
    input  logic rx_overflow,
    input  logic rx_not_empty,
    input  logic tx_not_full,
    input  logic mask_hi,
    input  logic mask_lo,
    input  logic glb_en,
    input  logic irq_clr,
    output logic irq_hi,
    output logic irq_lo
);
    irq_cfg_t               cfg;
    irq_src_t               src;
    logic                   cause;
    logic [NUM_LINES-1:0]   pend;
    logic [NUM_LINES-1:0]   mask;
    logic [NUM_LINES-1:0]   req;

    always_comb begin
        cfg = '{dma_en: cfg_dma_en, xfer_ie: cfg_xfer_ie,
                err_ie: cfg_err_ie, tx_init: cfg_tx_init};
        src = '{dma_done: dma_done, chain_done: chain_done, mm_err: mm_err,
                tx_underflow: tx_underflow, rx_overflow: rx_overflow,
                rx_not_empty: rx_not_empty, tx_not_full: tx_not_full};
        mask[LINE_HI] = mask_hi;
        mask[LINE_LO] = mask_lo;
    end

    spi_irq_cause u_cause (
        .cfg   (cfg),
        .src   (src),
        .cause (cause)
    );

    spi_irq_latch #(.LINES(NUM_LINES)) u_latch (
        .clk   (clk),
        .rst   (rst),
        .cause (cause),
        .clr   (irq_clr),
        .pend  (pend)
    );

    spi_irq_gate #(.LINES(NUM_LINES)) u_gate (
        .pend   (pend),
        .mask   (mask),
        .glb_en (glb_en),
        .req    (req)
    );

    assign irq_hi = req[LINE_HI];
    assign irq_lo = req[LINE_LO];
endmodule

// File: rtl/spi_irq_ctrl_chk.sv
module spi_irq_ctrl_chk
    import spi_irq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 cause,
    input logic                 irq_clr,
    input logic [NUM_LINES-1:0] pend,
    input logic                 cfg_dma_en,
    input logic                 cfg_err_ie,
    input logic                 cfg_tx_init,
    input logic                 tx_underflow,
    input logic                 rx_overflow,
    input logic                 mask_hi,
    input logic                 mask_lo,
    input logic                 glb_en,
    input logic                 irq_hi,
    input logic                 irq_lo
);
    // R3
    cause_sets_all_chk: assert property (@(posedge clk) disable iff (rst)
        cause |=> $countones(pend) == NUM_LINES);

    // R10
    clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_clr && !cause) |=> pend == '0);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_clr && !cause) |=> $stable(pend));

    // R9
    hi_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_hi |-> (mask_hi && glb_en));

    // R9
    lo_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_lo |-> (mask_lo && glb_en));

    // R6
    underflow_tx_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_dma_en && cfg_err_ie && cfg_tx_init && tx_underflow) |=> &pend);

    // R6
    overflow_rx_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_dma_en && cfg_err_ie && !cfg_tx_init && rx_overflow) |=> &pend);
endmodule

bind spi_irq_ctrl spi_irq_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cause        (cause),
    .irq_clr      (irq_clr),
    .pend         (pend),
    .cfg_dma_en   (cfg_dma_en),
    .cfg_err_ie   (cfg_err_ie),
    .cfg_tx_init  (cfg_tx_init),
    .tx_underflow (tx_underflow),
    .rx_overflow  (rx_overflow),
    .mask_hi      (mask_hi),
    .mask_lo      (mask_lo),
    .glb_en       (glb_en),
    .irq_hi       (irq_hi),
    .irq_lo       (irq_lo)
);

// File: tb/tb_spi_irq_ctrl.sv
module tb_spi_irq_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_dma_en = 0, cfg_xfer_ie = 0, cfg_err_ie = 0, cfg_tx_init = 0;
    logic dma_done = 0, chain_done = 0, mm_err = 0, tx_underflow = 0;
    logic rx_overflow = 0, rx_not_empty = 0, tx_not_full = 0;
    logic mask_hi = 1, mask_lo = 1, glb_en = 1, irq_clr = 0;
    logic irq_hi, irq_lo;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    spi_irq_ctrl dut (.*);

    // {dma, xie, eie, txi, done, chain, mm, unf, ovf, rne, tnf, expect}
    localparam logic [11:0] VEC [14] = '{
        12'b1100_1000_000_1, // R1 done with xfer enable
        12'b1100_0100_000_1, // R2 chain done
        12'b1000_1000_000_0, // R1 done, xfer enable off
        12'b1010_0010_000_1, // R5 multimaster
        12'b1011_0001_000_1, // R6 underflow, tx-init
        12'b1011_0000_100_0, // R6 overflow, tx-init
        12'b1010_0000_100_1, // R6 overflow, rx-init
        12'b1010_0001_000_0, // R6 underflow, rx-init
        12'b1100_0010_000_0, // R4 error with only xfer enable
        12'b1010_1100_000_0, // R4 done with only error enable
        12'b0000_0000_010_1, // R7 core rx not empty
        12'b0000_0000_001_1, // R7 core tx not full
        12'b0111_1111_100_0, // R8 core errors and pulses
        12'b1110_0000_011_0  // R7 buffer status in DMA mode
    };

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic quiet();
        {dma_done, chain_done, mm_err, tx_underflow, rx_overflow,
         rx_not_empty, tx_not_full} = '0;
    endtask

    task automatic clear_cycle();
        @(negedge clk);
        quiet();
        irq_clr = 1;
        @(negedge clk);
        irq_clr = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        check("R10 reset hi", irq_hi, 1'b0);
        check("R10 reset lo", irq_lo, 1'b0);

        foreach (VEC[i]) begin
            clear_cycle();
            {cfg_dma_en, cfg_xfer_ie, cfg_err_ie, cfg_tx_init} = VEC[i][11:8];
            {dma_done, chain_done, mm_err, tx_underflow} = VEC[i][7:4];
            {rx_overflow, rx_not_empty, tx_not_full} = VEC[i][3:1];
            @(negedge clk);
            quiet();
            check($sformatf("R3 vec%0d hi", i), irq_hi, VEC[i][0]);
            check($sformatf("R3 vec%0d lo", i), irq_lo, VEC[i][0]);
        end

        // R10: cause in same cycle as clear keeps latch set
        {cfg_dma_en, cfg_xfer_ie, cfg_err_ie, cfg_tx_init} = 4'b1100;
        clear_cycle();
        dma_done = 1; irq_clr = 1;
        @(negedge clk);
        dma_done = 0; irq_clr = 0;
        check("R10 clear vs cause", irq_hi, 1'b1);
        // R10: holds without clear
        repeat (3) @(negedge clk);
        check("R10 hold", irq_lo, 1'b1);
        clear_cycle();
        check("R10 cleared", irq_hi, 1'b0);

        // R9: masked pending request exposed on unmask
        mask_hi = 0; mask_lo = 0;
        dma_done = 1;
        @(negedge clk);
        dma_done = 0;
        check("R9 masked hi", irq_hi, 1'b0);
        check("R9 masked lo", irq_lo, 1'b0);
        repeat (2) @(negedge clk);
        mask_hi = 1;
        #1;
        check("R9 unmask hi", irq_hi, 1'b1);
        check("R9 lo stays masked", irq_lo, 1'b0);
        mask_lo = 1; glb_en = 0;
        #1;
        check("R9 global off hi", irq_hi, 1'b0);
        check("R9 global off lo", irq_lo, 1'b0);
        glb_en = 1;
        #1;
        check("R9 global on lo", irq_lo, 1'b1);

        // R10: synchronous reset clears pending
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        check("R10 reset clears", irq_hi, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule